// File: doc/BRIEF.md
# Serial-to-Parallel Word Converter with Bit Slip

This block gathers a serial bit stream into parallel words of `W` bits (8 by default) and produces a framing strobe that marks each new word. The serial source is picked from two inputs, A or B, so a link can be looped back onto the spare input for testing. Two capture rates are supported. In dual-rate mode each clock delivers a lane pair of two bits. In single-rate mode each clock delivers one bit.

A slip request moves the word boundary by one bit for each qualified pulse. The request may arrive asynchronously. It is synchronized, then it must stay high for a minimum number of clocks before it counts. Once it counts, exactly one incoming bit is dropped. A synchronous hold input freezes the whole datapath. An active-low asynchronous reset clears all state.

Top module: `s2p_conv`

## Requirements
- R1: The first bit gathered into a word appears on `word_o[0]`, the second on `word_o[1]`, and so on up to `word_o[W-1]`.
- R2: With `sel_b_i` = 0 the bits come from `ser_a_i`; with `sel_b_i` = 1 they come from `ser_b_i`. The unselected input has no effect on the outputs.
- R3: With `rate_single_i` = 1, one bit, `ser_x_i[0]`, is captured per active clock. `frame_o` then repeats every 8 active clocks: it is high for 4 and low for 4.
- R4: With `rate_single_i` = 0, two bits are captured per active clock, `ser_x_i[0]` first and `ser_x_i[1]` second. `frame_o` then repeats every 4 active clocks: it is high for 2 and low for 2.
- R5: `word_o` updates 6 active edges (dual-rate) or 12 active edges (single-rate) after the edge that captured the word's first bit, provided no slip falls inside the word. Measured from the edge that captured the word's last bit, the delay is 3 or 5 edges.
- R6: `slip_i` passes through a two-flop synchronizer. A request qualifies only when the synchronized level has been high on 2 consecutive active edges (dual-rate) or 3 (single-rate). Shorter pulses leave the word stream unchanged.
- R7: A qualified request drops exactly one bit on the next capture edge. In dual-rate mode the dropped bit is the earlier bit of that pair, even when this splits a pair across two words.
- R8: One pulse gives at most one slip, no matter how long `slip_i` stays high. Each further slip needs a new pulse.
- R9: While `hold_i` = 1 at a clock edge, that edge captures nothing, and `word_o`, `frame_o` and all internal progress stay unchanged. Operation resumes when `hold_i` returns to 0.
- R10: While `rst_ni` = 0, `word_o` = 0 and `frame_o` = 0, whatever `hold_i` is. After release, the first rising edge captures nothing, and the first data bit is captured on the second rising edge.
- R11: `frame_o` rises on the same edge that loads a new word into `word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_single_i | input | 1 | 1 = one bit per clock, 0 = lane pair per clock |
| sel_b_i | input | 1 | Serial source select, 0 = A, 1 = B |
| ser_a_i | input | 2 | Serial input A, bit 0 earlier |
| ser_b_i | input | 2 | Serial input B, bit 0 earlier |
| slip_i | input | 1 | Asynchronous bit-slip request |
| hold_i | input | 1 | Synchronous freeze |
| word_o | output | W | Parallel word |
| frame_o | output | 1 | Word framing strobe |

## Verification
A fixed pattern runs right after reset in each rate. A flipped first-edge value tells a capture on the first edge apart from a capture on the second. The expected byte separates the two bit orders and the two latencies. Random lane data runs on both sources, with only one source selected, to expose any leak from the unselected input. Slip pulses of widths just below, at and well above the qualifying width show whether a pulse is ignored, slips once, or slips repeatedly. Back-to-back qualified slips force lane pairs to split across words. Hold windows placed inside words and inside slip pulses show whether progress freezes.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  typedef enum logic {
    RATE_DUAL   = 1'b0,
    RATE_SINGLE = 1'b1
  } rate_e;
endpackage

// File: rtl/s2p_slip_qual.sv
module s2p_slip_qual #(
  parameter int unsigned MIN_DUAL   = 2,
  parameter int unsigned MIN_SINGLE = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  s2p_pkg::rate_e  rate_i,
  input  logic            slip_i,
  output logic            qual_o
);
  localparam int unsigned MAXW = (MIN_DUAL > MIN_SINGLE) ? MIN_DUAL : MIN_SINGLE;
  localparam int unsigned WCW  = $clog2(MAXW + 1);

  logic           s1_q, s2_q;
  logic [WCW-1:0] wc_q, min_w;

  assign min_w  = (rate_i == s2p_pkg::RATE_SINGLE) ? WCW'(MIN_SINGLE) : WCW'(MIN_DUAL);
  assign qual_o = adv_i && s2_q && (wc_q == min_w - WCW'(1));

  // synchronizer runs free; width counter freezes with the datapath
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      wc_q <= '0;
    end else begin
      s1_q <= slip_i;
      s2_q <= s1_q;
      if (adv_i) begin
        if (!s2_q)            wc_q <= '0;
        else if (wc_q < min_w) wc_q <= wc_q + WCW'(1);
      end
    end
  end

  // R8
  one_slip_per_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |=> !qual_o);
  // R6
  min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> (s2_q && $past(s2_q)));
endmodule

// File: rtl/s2p_pack.sv
module s2p_pack #(
  parameter int unsigned W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  s2p_pkg::rate_e  rate_i,
  input  logic [1:0]      lane_i,
  input  logic            drop_i,
  output logic            full_o,
  output logic [W-1:0]    word_o
);
  localparam int unsigned CW = $clog2(W) + 1;
  localparam int unsigned IW = $clog2(W);

  logic [W-1:0]  acc_q, asm_w, nxt_w;
  logic [CW-1:0] cnt_q, tot_w, cnt_nxt;
  logic [1:0]    bits_w, n_w;

  always_comb begin
    if (rate_i == s2p_pkg::RATE_SINGLE) begin
      bits_w = {1'b0, lane_i[0]};
      n_w    = drop_i ? 2'd0 : 2'd1;
    end else if (drop_i) begin
      bits_w = {1'b0, lane_i[1]};       // earlier bit of the pair is dropped
      n_w    = 2'd1;
    end else begin
      bits_w = lane_i;
      n_w    = 2'd2;
    end
    tot_w  = cnt_q + CW'(n_w);
    full_o = cap_i && (tot_w >= CW'(W));
    asm_w  = acc_q;
    nxt_w  = '0;
    for (int i = 0; i < 2; i++) begin
      if (i < int'(n_w)) begin
        if (int'(cnt_q) + i < int'(W)) asm_w[IW'(int'(cnt_q) + i)] = bits_w[i];
        else                           nxt_w[IW'(int'(cnt_q) + i - int'(W))] = bits_w[i];
      end
    end
    if (!full_o) nxt_w = asm_w;
    cnt_nxt = full_o ? (tot_w - CW'(W)) : tot_w;
  end

  assign word_o = asm_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (cap_i) begin
      acc_q <= nxt_w;
      cnt_q <= cnt_nxt;
    end
  end

  // R7
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(W));
endmodule

// File: rtl/s2p_delay.sv
module s2p_delay #(
  parameter int unsigned W        = 8,
  parameter int unsigned TAP_DUAL = 3,
  parameter int unsigned TAP_SGL  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  s2p_pkg::rate_e  rate_i,
  input  logic            in_v_i,
  input  logic [W-1:0]    in_d_i,
  output logic            out_v_o,
  output logic [W-1:0]    out_d_o
);
  localparam int unsigned DEPTH = (TAP_DUAL > TAP_SGL) ? TAP_DUAL : TAP_SGL;

  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     d_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) d_q[i] <= '0;
    end else if (adv_i) begin
      v_q[0] <= in_v_i;
      d_q[0] <= in_d_i;
      for (int i = 1; i < int'(DEPTH); i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_v_o = (rate_i == s2p_pkg::RATE_SINGLE) ? v_q[TAP_SGL-1] : v_q[TAP_DUAL-1];
  assign out_d_o = (rate_i == s2p_pkg::RATE_SINGLE) ? d_q[TAP_SGL-1] : d_q[TAP_DUAL-1];

  // R5: words are at least several captures apart
  word_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q[0] && adv_i) |=> !v_q[0]);
endmodule

// File: rtl/s2p_frame.sv
module s2p_frame #(
  parameter int unsigned W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  s2p_pkg::rate_e  rate_i,
  input  logic            load_i,
  output logic            frame_o
);
  localparam int unsigned HALF_DUAL = W / 4;
  localparam int unsigned HALF_SGL  = W / 2;
  localparam int unsigned HW        = $clog2(HALF_SGL + 1);

  logic [HW-1:0] cnt_q, half_w;

  assign half_w = (rate_i == s2p_pkg::RATE_SINGLE) ? HW'(HALF_SGL) : HW'(HALF_DUAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      frame_o <= 1'b0;
    end else if (adv_i) begin
      if (load_i) begin
        frame_o <= 1'b1;
        cnt_q   <= HW'(1);
      end else begin
        if (cnt_q >= half_w) frame_o <= 1'b0;
        if (cnt_q <  half_w) cnt_q   <= cnt_q + HW'(1);
      end
    end
  end
endmodule

// File: rtl/s2p_conv.sv
module s2p_conv #(
  parameter int unsigned W        = 8,
  parameter int unsigned LAT_DUAL = 6,
  parameter int unsigned LAT_SGL  = 12,
  parameter int unsigned SLIP_DUAL = 2,
  parameter int unsigned SLIP_SGL  = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rate_single_i,
  input  logic         sel_b_i,
  input  logic [1:0]   ser_a_i,
  input  logic [1:0]   ser_b_i,
  input  logic         slip_i,
  input  logic         hold_i,
  output logic [W-1:0] word_o,
  output logic         frame_o
);
  localparam int unsigned TAP_DUAL = LAT_DUAL - W / 2 + 1;
  localparam int unsigned TAP_SGL  = LAT_SGL - W + 1;

  s2p_pkg::rate_e rate;
  logic           adv, run_q, cap, qual, pend_q, full, tap_v;
  logic [1:0]     lane;
  logic [W-1:0]   asm_d, tap_d;

  assign rate = s2p_pkg::rate_e'(rate_single_i);
  assign adv  = !hold_i;
  assign cap  = adv && run_q;
  assign lane = sel_b_i ? ser_b_i : ser_a_i;

  // first active edge after reset only arms capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (adv) begin
      run_q <= 1'b1;
      if (qual)     pend_q <= 1'b1;
      else if (cap) pend_q <= 1'b0;
    end
  end

  s2p_slip_qual #(.MIN_DUAL(SLIP_DUAL), .MIN_SINGLE(SLIP_SGL)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .rate_i(rate),
    .slip_i(slip_i), .qual_o(qual));

  s2p_pack #(.W(W)) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .rate_i(rate),
    .lane_i(lane), .drop_i(pend_q), .full_o(full), .word_o(asm_d));

  s2p_delay #(.W(W), .TAP_DUAL(TAP_DUAL), .TAP_SGL(TAP_SGL)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .rate_i(rate),
    .in_v_i(full), .in_d_i(asm_d), .out_v_o(tap_v), .out_d_o(tap_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            word_o <= '0;
    else if (adv && tap_v)  word_o <= tap_d;
  end

  s2p_frame #(.W(W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .rate_i(rate),
    .load_i(adv && tap_v), .frame_o(frame_o));

  // R9
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(word_o) && $stable(frame_o)));
  // R11
  frame_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> $rose(frame_o));
endmodule

// File: tb/tb_s2p_conv.sv
`timescale 1ns/1ps
module tb_s2p_conv;
  logic       clk_i = 1'b0, rst_ni = 1'b0, rate_single_i = 1'b0, sel_b_i = 1'b0;
  logic       slip_i = 1'b0, hold_i = 1'b0;
  logic [1:0] ser_a_i = '0, ser_b_i = '0;
  logic [7:0] word_o;
  logic       frame_o;

  always #4 clk_i = ~clk_i;

  s2p_conv dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_single_i(rate_single_i), .sel_b_i(sel_b_i),
    .ser_a_i(ser_a_i), .ser_b_i(ser_b_i), .slip_i(slip_i), .hold_i(hold_i),
    .word_o(word_o), .frame_o(frame_o));

  localparam logic [63:0] PAT = 64'h3C5A_F00F_1E2D_4B96;

  int    tests = 0, fails = 0;
  string tag = "R10";
  bit    cmp_en = 1'b0;

  // behavioural reference
  bit         m_s1, m_s2, m_pend, m_run, m_frame;
  int         m_wc, m_since;
  logic [7:0] m_word;
  bit         mq[$];
  logic [7:0] pw[$];
  int         pr[$];

  always @(posedge clk_i or negedge rst_ni) begin : model
    bit s2o, sg, ld, q;
    logic [1:0] ln;
    logic [7:0] w;
    int mn, tmp;
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_wc = 0; m_pend = 0; m_run = 0;
      mq.delete(); pw.delete(); pr.delete();
      m_word = '0; m_frame = 0; m_since = 100;
    end else begin
      s2o = m_s2; m_s2 = m_s1; m_s1 = slip_i;
      if (!hold_i) begin
        sg = rate_single_i;
        ln = sel_b_i ? ser_b_i : ser_a_i;
        ld = 0;
        foreach (pr[i]) pr[i] = pr[i] - 1;
        if (pr.size() > 0 && pr[0] == 0) begin
          m_word = pw.pop_front();
          tmp = pr.pop_front();
          ld = 1;
        end
        if (ld) m_since = 0;
        else if (m_since < 100) m_since++;
        m_frame = (m_since < (sg ? 4 : 2));
        if (m_run) begin
          if (sg) begin
            if (!m_pend) mq.push_back(ln[0]);
          end else begin
            if (!m_pend) mq.push_back(ln[0]);
            mq.push_back(ln[1]);
          end
          m_pend = 0;
          if (mq.size() >= 8) begin
            for (int k = 0; k < 8; k++) w[k] = mq.pop_front();
            pw.push_back(w);
            pr.push_back(sg ? 5 : 3);
          end
        end
        mn = sg ? 3 : 2;
        q = s2o && (m_wc == mn - 1);
        if (!s2o) m_wc = 0;
        else if (m_wc < mn) m_wc++;
        if (q) m_pend = 1;
        m_run = 1;
      end
    end
  end

  task automatic chk(string t, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (cmp_en) begin
    chk(tag, word_o, m_word);
    chk(tag, {7'd0, frame_o}, {7'd0, m_frame});
  end

  task automatic rnd(int n);
    repeat (n) begin
      @(negedge clk_i);
      ser_a_i = 2'($urandom);
      ser_b_i = 2'($urandom);
    end
  endtask

  task automatic slip_pulse(int w, int gap);
    repeat (w) begin
      @(negedge clk_i);
      slip_i = 1'b1;
      ser_a_i = 2'($urandom);
      ser_b_i = 2'($urandom);
    end
    @(negedge clk_i);
    slip_i = 1'b0;
    rnd(gap);
  endtask

  task automatic hold_win(int n, int gap);
    @(negedge clk_i);
    hold_i = 1'b1;
    rnd(n);
    @(negedge clk_i);
    hold_i = 1'b0;
    rnd(gap);
  endtask

  // directed start: reset, then known pattern; edge 1 carries ones
  task automatic directed(bit sgl, bit useb);
    int lat, half;
    logic [1:0] v;
    lat  = sgl ? 12 : 6;
    half = sgl ? 4 : 2;
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    rate_single_i = sgl; sel_b_i = useb; slip_i = 0; hold_i = 1'b1;
    repeat (2) @(negedge clk_i);
    tag = "R10";
    chk("R10 reset word", word_o, 8'h00);
    chk("R10 reset frame", {7'd0, frame_o}, 8'h00);
    hold_i = 1'b0;
    rst_ni = 1'b1;
    if (useb) begin ser_b_i = 2'b11; ser_a_i = 2'b00; end
    else      begin ser_a_i = 2'b11; ser_b_i = 2'b00; end
    tag = useb ? "R2" : (sgl ? "R3" : "R4");
    for (int j = 0; j < 24; j++) begin
      @(negedge clk_i);
      if (j == lat)     chk("R5 before latency", word_o, 8'h00);
      if (j == lat + 1) begin
        chk("R1 R5 R10 first word", word_o, PAT[7:0]);
        chk("R11 frame rises with word", {7'd0, frame_o}, 8'h01);
      end
      if (j == lat + half)     chk(sgl ? "R3 frame high" : "R4 frame high", {7'd0, frame_o}, 8'h01);
      if (j == lat + half + 1) chk(sgl ? "R3 frame low" : "R4 frame low", {7'd0, frame_o}, 8'h00);
      v = sgl ? {1'b0, PAT[j]} : {PAT[2*j+1], PAT[2*j]};
      if (useb) begin ser_b_i = v; ser_a_i = ~v; end
      else      begin ser_a_i = v; ser_b_i = ~v; end
    end
  endtask

  initial begin : watchdog
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cmp_en = 1'b1;
    directed(1'b0, 1'b0);
    tag = "R4"; rnd(40);
    tag = "R6"; slip_pulse(1, 20);
    tag = "R7"; slip_pulse(2, 20); slip_pulse(2, 6); slip_pulse(3, 6); slip_pulse(2, 20);
    tag = "R8"; slip_pulse(14, 20);
    tag = "R9"; hold_win(5, 10); hold_win(3, 0); slip_pulse(2, 2); hold_win(2, 20);
    tag = "R2"; @(negedge clk_i); sel_b_i = 1'b1; rnd(30);
    directed(1'b1, 1'b1);
    tag = "R3"; rnd(40);
    tag = "R6"; slip_pulse(2, 30); slip_pulse(1, 30);
    tag = "R7"; slip_pulse(3, 30); slip_pulse(4, 12);
    tag = "R8"; slip_pulse(16, 30);
    tag = "R9"; hold_win(7, 10); slip_pulse(1, 0); hold_win(2, 30);
    tag = "R2"; @(negedge clk_i); sel_b_i = 1'b0; rnd(30);
    directed(1'b0, 1'b1);
    tag = "R7"; slip_pulse(2, 3); slip_pulse(2, 3); slip_pulse(5, 30);
    tag = "R10"; @(negedge clk_i); #1 rst_ni = 1'b0; rnd(3);
    @(negedge clk_i); rst_ni = 1'b1; rnd(40);
    cmp_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule